// File: doc/BRIEF.md
# Segmented Data Address Decoder

This block sits between the data side of a 16-bit microcontroller core and its memories. Each cycle it takes at most one data request and routes it to one of four targets: on-chip RAM, built-in special-function registers (SFRs), the external SFR port, or external memory. It also produces the local offset inside the chosen target, a 24-bit external address and the byte-lane enables with lane-aligned write data. The routing result appears on registered outputs one clock after the request.

Routing depends on the addressing mode. Direct addresses use 11 bits. Their upper half is an SFR window that ignores the segment registers. Indirect accesses can never reach SFRs. Below the SFR window, routing depends on whether the data segment register is zero. A move-external request always goes off-chip. The block holds two 8-bit segment registers, a data segment (DSEG) and an extra segment (XSEG), which are written through a small load port. One of them supplies the top byte of the external address.

Top module: `seg_addr_router`

## Requirements
- R1: After reset, out_valid, all four selects, out_we and bit_err are 0, and both segment registers are 0. A move-external request made after reset therefore yields ext_addr[23:16] = 0x00.
- R2: A direct request uses only req_addr[10:0]; bits 15:11 are ignored. A direct address from 0x400 to 0x5FF asserts sel_isfr with out_offset = address − 0x400, whatever the segment registers hold.
- R3: A direct address from 0x600 to 0x7FF asserts sel_xsfr with out_offset = address − 0x600, whatever the segment registers hold.
- R4: A direct address below 0x400 selects on-chip RAM (out_offset = address) when DSEG is 0. When DSEG is nonzero it selects external memory.
- R5: An indirect request never selects an SFR target. When DSEG is 0 and the address is below IRAM_SIZE (default 2048), it selects on-chip RAM; otherwise it selects external memory.
- R6: A request with req_movx = 1 always selects external memory, including addresses that overlap on-chip RAM.
- R7: When external memory is selected, ext_addr = {segment, aligned 16-bit address}, where the segment is XSEG if req_use_xseg = 1 and DSEG otherwise. In every other case ext_addr = 0. A load (seg_load_sel 0 = DSEG, 1 = XSEG) is seen only by requests in later cycles.
- R8: The data is little endian. A word request clears address bit 0, sets lane_en = 2'b11 (bit 0 is the even byte) and passes req_wdata unchanged. A byte request sets lane_en = 2'b01 at an even address and 2'b10 at an odd address, and drives {wdata[7:0], wdata[7:0]}.
- R9: A bit request (req_bit = 1) is handled as a byte access and is allowed only for a direct, non-move-external address from 0x400 to 0x43F. Any other bit request sets bit_err = 1, asserts no select and forces out_we = 0.
- R10: Outputs register the request one cycle later. At most one select is high at a time. A cycle with req_valid = 0 is followed by out_valid = 0 with no select. out_we = req_we when the request is routed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_load | input | 1 | Write a segment register this cycle |
| seg_load_sel | input | 1 | 0 = DSEG, 1 = XSEG |
| seg_load_val | input | 8 | New segment value |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Request address |
| req_direct | input | 1 | 1 = direct addressing, 0 = indirect |
| req_movx | input | 1 | Force external memory |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_bit | input | 1 | Bit-level access |
| req_use_xseg | input | 1 | Use XSEG for the external address |
| req_wdata | input | 16 | Write data |
| req_we | input | 1 | Write enable |
| out_valid | output | 1 | Registered request valid |
| sel_iram | output | 1 | On-chip RAM select |
| sel_isfr | output | 1 | Built-in SFR select |
| sel_xsfr | output | 1 | External SFR port select |
| sel_xmem | output | 1 | External memory select |
| out_offset | output | 16 | Offset inside the selected target |
| ext_addr | output | 24 | External memory address |
| lane_en | output | 2 | Byte-lane enables, bit 0 = even byte |
| lane_wdata | output | 16 | Lane-aligned write data |
| out_we | output | 1 | Write strobe |
| bit_err | output | 1 | Illegal bit access |

## Verification
The hardest situation to reach is a segment load and a request in the same cycle. Here the router must still use the old DSEG, and the new value must take effect on the very next request. The bench drives both on one falling edge and then repeats the request. A second awkward case is an address that matches several rules at once, for example an indirect 0x0500 with DSEG zero, or a move-external to a low address. The bench sends those addresses deliberately under both DSEG states to show which rule has priority.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_IRAM = 3'd1,
    TGT_ISFR = 3'd2,
    TGT_XSFR = 3'd3,
    TGT_XMEM = 3'd4
  } tgt_e;

  localparam int DIR_BITS = 11;
  localparam logic [15:0] SFR_BASE  = 16'h0400;
  localparam logic [15:0] XSFR_BASE = 16'h0600;
  localparam logic [15:0] BIT_TOP   = 16'h043F;

  function automatic logic [15:0] align_addr(input logic [15:0] a, input logic word);
    return word ? {a[15:1], 1'b0} : a;
  endfunction

  function automatic logic [15:0] direct_addr(input logic [15:0] a);
    return {{(16-DIR_BITS){1'b0}}, a[DIR_BITS-1:0]};
  endfunction

  function automatic logic in_window(input logic [15:0] a, input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/seg_regs.sv
module seg_regs #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_sel,
  input  logic [SEG_W-1:0] load_val,
  output logic [SEG_W-1:0] dseg,
  output logic [SEG_W-1:0] xseg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dseg <= '0;
      xseg <= '0;
    end else if (load) begin
      if (load_sel) xseg <= load_val;
      else          dseg <= load_val;
    end
  end

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dseg) && $stable(xseg))); // R7
endmodule

// File: rtl/region_decode.sv
module region_decode
  import seg_addr_pkg::*;
#(
  parameter int IRAM_SIZE = 2048
) (
  input  logic [15:0] addr,
  input  logic        direct,
  input  logic        movx,
  input  logic        word,
  input  logic        bit_acc,
  input  logic        dseg_zero,
  output tgt_e        tgt,
  output logic        bit_err,
  output logic [15:0] eff_addr,
  output logic [15:0] local_off
);
  logic [15:0] raw;
  logic        bit_ok;
  logic        below_iram;

  always_comb begin
    raw        = direct ? direct_addr(addr) : addr;
    eff_addr   = align_addr(raw, word && !bit_acc);
    bit_ok     = direct && !movx && in_window(eff_addr, SFR_BASE, BIT_TOP);
    below_iram = ({16'd0, eff_addr} < 32'(IRAM_SIZE));
    bit_err    = 1'b0;
    if (bit_acc && !bit_ok) begin
      bit_err = 1'b1;
      tgt     = TGT_NONE;
    end else if (movx) begin
      tgt = TGT_XMEM;
    end else if (direct) begin
      if (eff_addr >= XSFR_BASE)     tgt = TGT_XSFR;
      else if (eff_addr >= SFR_BASE) tgt = TGT_ISFR;
      else if (dseg_zero)            tgt = TGT_IRAM;
      else                           tgt = TGT_XMEM;
    end else begin
      tgt = (dseg_zero && below_iram) ? TGT_IRAM : TGT_XMEM;
    end
    case (tgt)
      TGT_ISFR: local_off = eff_addr - SFR_BASE;
      TGT_XSFR: local_off = eff_addr - XSFR_BASE;
      default:  local_off = eff_addr;
    endcase
  end

  always_comb begin
    if (!direct) AST_IND_NO_SFR: assert (tgt != TGT_ISFR && tgt != TGT_XSFR); // R5
  end
endmodule

// File: rtl/lane_gen.sv
module lane_gen (
  input  logic        word,
  input  logic        a0,
  input  logic [15:0] wdata,
  output logic [1:0]  lane_en,
  output logic [15:0] lane_wdata
);
  always_comb begin
    if (word) begin
      lane_en    = 2'b11;
      lane_wdata = wdata;
    end else begin
      lane_en    = a0 ? 2'b10 : 2'b01;
      lane_wdata = {wdata[7:0], wdata[7:0]};
    end
  end
endmodule

// File: rtl/seg_addr_router.sv
module seg_addr_router
  import seg_addr_pkg::*;
#(
  parameter int IRAM_SIZE = 2048,
  parameter int SEG_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_load,
  input  logic        seg_load_sel,
  input  logic [7:0]  seg_load_val,
  input  logic        req_valid,
  input  logic [15:0] req_addr,
  input  logic        req_direct,
  input  logic        req_movx,
  input  logic        req_word,
  input  logic        req_bit,
  input  logic        req_use_xseg,
  input  logic [15:0] req_wdata,
  input  logic        req_we,
  output logic        out_valid,
  output logic        sel_iram,
  output logic        sel_isfr,
  output logic        sel_xsfr,
  output logic        sel_xmem,
  output logic [15:0] out_offset,
  output logic [23:0] ext_addr,
  output logic [1:0]  lane_en,
  output logic [15:0] lane_wdata,
  output logic        out_we,
  output logic        bit_err
);
  localparam int EXT_W = SEG_W + 16;

  logic [SEG_W-1:0] dseg, xseg;
  tgt_e             tgt;
  logic             dec_err;
  logic [15:0]      eff_addr, local_off;
  logic [1:0]       lane_c;
  logic [15:0]      wdata_c;
  logic             acc_word;
  logic [EXT_W-1:0] ext_c;
  logic             was_direct;

  seg_regs #(.SEG_W(SEG_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .load(seg_load), .load_sel(seg_load_sel),
    .load_val(seg_load_val[SEG_W-1:0]), .dseg(dseg), .xseg(xseg)
  );

  region_decode #(.IRAM_SIZE(IRAM_SIZE)) u_dec (
    .addr(req_addr), .direct(req_direct), .movx(req_movx), .word(req_word),
    .bit_acc(req_bit), .dseg_zero(dseg == '0), .tgt(tgt), .bit_err(dec_err),
    .eff_addr(eff_addr), .local_off(local_off)
  );

  assign acc_word = req_word && !req_bit;

  lane_gen u_lane (
    .word(acc_word), .a0(eff_addr[0]), .wdata(req_wdata),
    .lane_en(lane_c), .lane_wdata(wdata_c)
  );

  assign ext_c = (tgt == TGT_XMEM) ? {(req_use_xseg ? xseg : dseg), eff_addr} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      sel_iram   <= 1'b0;
      sel_isfr   <= 1'b0;
      sel_xsfr   <= 1'b0;
      sel_xmem   <= 1'b0;
      out_offset <= '0;
      ext_addr   <= '0;
      lane_en    <= '0;
      lane_wdata <= '0;
      out_we     <= 1'b0;
      bit_err    <= 1'b0;
      was_direct <= 1'b0;
    end else begin
      out_valid  <= req_valid;
      sel_iram   <= req_valid && (tgt == TGT_IRAM);
      sel_isfr   <= req_valid && (tgt == TGT_ISFR);
      sel_xsfr   <= req_valid && (tgt == TGT_XSFR);
      sel_xmem   <= req_valid && (tgt == TGT_XMEM);
      out_offset <= req_valid ? local_off : '0;
      ext_addr   <= req_valid ? 24'(ext_c) : '0;
      lane_en    <= req_valid ? lane_c : '0;
      lane_wdata <= req_valid ? wdata_c : '0;
      out_we     <= req_valid && req_we && !dec_err;
      bit_err    <= req_valid && dec_err;
      was_direct <= req_valid && req_direct && !req_movx;
    end
  end

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_iram, sel_isfr, sel_xsfr, sel_xmem})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !sel_iram && !sel_isfr && !sel_xsfr && !sel_xmem)); // R10
  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> (!sel_iram && !sel_isfr && !sel_xsfr && !sel_xmem && !out_we)); // R9
  AST_SFR_DIRECT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_isfr || sel_xsfr) |-> was_direct); // R5
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lane_en == 2'b11) |-> !out_offset[0]); // R8
  AST_EXT_ONLY_XMEM: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_xmem |-> (ext_addr == '0)); // R7
endmodule

// File: tb/seg_addr_router_test.sv
module seg_addr_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seg_load = 0, seg_load_sel = 0;
  logic [7:0] seg_load_val = 0;
  logic req_valid = 0, req_direct = 0, req_movx = 0, req_word = 0, req_bit = 0;
  logic req_use_xseg = 0, req_we = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic out_valid, sel_iram, sel_isfr, sel_xsfr, sel_xmem, out_we, bit_err;
  logic [15:0] out_offset, lane_wdata;
  logic [23:0] ext_addr;
  logic [1:0] lane_en;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_addr_router uut (
    .clk(clk), .rst_n(rst_n), .seg_load(seg_load), .seg_load_sel(seg_load_sel),
    .seg_load_val(seg_load_val), .req_valid(req_valid), .req_addr(req_addr),
    .req_direct(req_direct), .req_movx(req_movx), .req_word(req_word),
    .req_bit(req_bit), .req_use_xseg(req_use_xseg), .req_wdata(req_wdata),
    .req_we(req_we), .out_valid(out_valid), .sel_iram(sel_iram), .sel_isfr(sel_isfr),
    .sel_xsfr(sel_xsfr), .sel_xmem(sel_xmem), .out_offset(out_offset),
    .ext_addr(ext_addr), .lane_en(lane_en), .lane_wdata(lane_wdata),
    .out_we(out_we), .bit_err(bit_err)
  );

  // packing: sel{iram,isfr,xsfr,xmem}, offset, ext, lanes, wdata, we, err
  function automatic logic [63:0] mk(input logic [3:0] s, input logic [15:0] off,
      input logic [23:0] ext, input logic [1:0] ln, input logic [15:0] wd,
      input logic we, input logic err);
    return {s, off, ext, ln, wd, we, err};
  endfunction

  function automatic logic [63:0] actual();
    return {sel_iram, sel_isfr, sel_xsfr, sel_xmem, out_offset, ext_addr,
            lane_en, lane_wdata, out_we, bit_err};
  endfunction

  task automatic chk(input string tag, input logic [63:0] exp);
    checks++;
    if (actual() !== exp || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s: actual=%h valid=%b expected=%h", tag, actual(), out_valid, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic dir, input logic mx,
      input logic w, input logic b, input logic xs, input logic [15:0] wd, input logic we);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_direct = dir; req_movx = mx; req_word = w;
    req_bit = b; req_use_xseg = xs; req_wdata = wd; req_we = we;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic load_seg(input logic sel, input logic [7:0] v);
    @(negedge clk);
    seg_load = 1; seg_load_sel = sel; seg_load_val = v;
    @(negedge clk);
    seg_load = 0;
  endtask

  task automatic t_reset();
    checks++;
    if ({out_valid, sel_iram, sel_isfr, sel_xsfr, sel_xmem, out_we, bit_err} !== 7'b0) begin
      errors++;
      $display("FAIL R1 reset: actual=%b expected=0",
        {out_valid, sel_iram, sel_isfr, sel_xsfr, sel_xmem, out_we, bit_err});
    end
    send(16'h0010, 0, 1, 0, 0, 1, 16'h0000, 0);
    chk("R1 segs zero after reset", mk(4'b0001, 16'h0010, 24'h000010, 2'b01, 16'h0000, 0, 0));
  endtask

  task automatic t_sfr();
    send(16'h0412, 1, 0, 0, 0, 0, 16'h0077, 1);
    chk("R2 isfr", mk(4'b0100, 16'h0012, 0, 2'b01, 16'h7777, 1, 0));
    send(16'hFC12, 1, 0, 0, 0, 0, 16'h0000, 0);
    chk("R2 upper bits ignored", mk(4'b0100, 16'h0012, 0, 2'b01, 16'h0000, 0, 0));
    send(16'h06A5, 1, 0, 0, 0, 0, 16'h0000, 0);
    chk("R3 xsfr", mk(4'b0010, 16'h00A5, 0, 2'b10, 16'h0000, 0, 0));
  endtask

  task automatic t_dseg_zero();
    send(16'h0123, 1, 0, 0, 0, 0, 16'h0000, 0);
    chk("R4 direct iram", mk(4'b1000, 16'h0123, 0, 2'b10, 16'h0000, 0, 0));
    send(16'h0500, 0, 0, 0, 0, 0, 16'h0000, 0);
    chk("R5 indirect 0x500 iram", mk(4'b1000, 16'h0500, 0, 2'b01, 16'h0000, 0, 0));
    send(16'h07FE, 0, 0, 1, 0, 0, 16'h1234, 0);
    chk("R5 indirect top iram", mk(4'b1000, 16'h07FE, 0, 2'b11, 16'h1234, 0, 0));
    send(16'h0800, 0, 0, 0, 0, 0, 16'h0000, 0);
    chk("R5 indirect above iram", mk(4'b0001, 16'h0800, 24'h000800, 2'b01, 16'h0000, 0, 0));
    send(16'h0010, 0, 1, 0, 0, 0, 16'h0000, 0);
    chk("R6 movx low", mk(4'b0001, 16'h0010, 24'h000010, 2'b01, 16'h0000, 0, 0));
  endtask

  task automatic t_dseg_nonzero();
    load_seg(0, 8'h12);
    send(16'h0123, 1, 0, 0, 0, 0, 16'h0000, 0);
    chk("R4 direct xmem", mk(4'b0001, 16'h0123, 24'h120123, 2'b10, 16'h0000, 0, 0));
    send(16'h0500, 0, 0, 0, 0, 0, 16'h0000, 0);
    chk("R5 indirect xmem", mk(4'b0001, 16'h0500, 24'h120500, 2'b01, 16'h0000, 0, 0));
    send(16'h0450, 1, 0, 0, 0, 0, 16'h0000, 0);
    chk("R2 isfr ignores seg", mk(4'b0100, 16'h0050, 0, 2'b01, 16'h0000, 0, 0));
    load_seg(1, 8'h34);
    send(16'h2000, 0, 0, 0, 0, 1, 16'h0000, 0);
    chk("R7 xseg", mk(4'b0001, 16'h2000, 24'h342000, 2'b01, 16'h0000, 0, 0));
    load_seg(0, 8'h00);
    send(16'h0010, 0, 1, 0, 0, 1, 16'h0000, 0);
    chk("R6 movx xseg", mk(4'b0001, 16'h0010, 24'h340010, 2'b01, 16'h0000, 0, 0));
  endtask

  task automatic t_same_cycle_load();
    @(negedge clk);
    seg_load = 1; seg_load_sel = 0; seg_load_val = 8'h55;
    req_valid = 1; req_addr = 16'h0010; req_direct = 1; req_movx = 0; req_word = 0;
    req_bit = 0; req_use_xseg = 0; req_wdata = 0; req_we = 0;
    @(negedge clk);
    seg_load = 0; req_valid = 0;
    chk("R7 old dseg used", mk(4'b1000, 16'h0010, 0, 2'b01, 16'h0000, 0, 0));
    send(16'h0010, 1, 0, 0, 0, 0, 16'h0000, 0);
    chk("R7 new dseg next", mk(4'b0001, 16'h0010, 24'h550010, 2'b01, 16'h0000, 0, 0));
    load_seg(0, 8'h00);
  endtask

  task automatic t_lanes();
    send(16'h0101, 0, 0, 1, 0, 0, 16'hBEEF, 1);
    chk("R8 word odd aligned", mk(4'b1000, 16'h0100, 0, 2'b11, 16'hBEEF, 1, 0));
    send(16'h0101, 0, 0, 0, 0, 0, 16'h00AB, 1);
    chk("R8 byte odd", mk(4'b1000, 16'h0101, 0, 2'b10, 16'hABAB, 1, 0));
    send(16'h0604, 1, 0, 0, 0, 0, 16'h00CD, 0);
    chk("R8 byte even", mk(4'b0010, 16'h0004, 0, 2'b01, 16'hCDCD, 0, 0));
  endtask

  task automatic t_bits();
    send(16'h043F, 1, 0, 0, 1, 0, 16'h0001, 1);
    chk("R9 bit ok", mk(4'b0100, 16'h003F, 0, 2'b10, 16'h0101, 1, 0));
    send(16'h0440, 1, 0, 0, 1, 0, 16'h0001, 1);
    chk("R9 bit out of window", mk(4'b0000, 16'h0440, 0, 2'b01, 16'h0101, 0, 1));
    send(16'h0410, 0, 0, 0, 1, 0, 16'h0000, 1);
    chk("R9 bit indirect", mk(4'b0000, 16'h0410, 0, 2'b01, 16'h0000, 0, 1));
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 0; req_addr = 16'h0412; req_direct = 1; req_we = 1;
    @(negedge clk);
    checks++;
    if ({out_valid, sel_iram, sel_isfr, sel_xsfr, sel_xmem, out_we} !== 6'b0) begin
      errors++;
      $display("FAIL R10 idle: actual=%b expected=0",
        {out_valid, sel_iram, sel_isfr, sel_xsfr, sel_xmem, out_we});
    end
    req_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sfr();
    t_dseg_zero();
    t_dseg_nonzero();
    t_same_cycle_load();
    t_lanes();
    t_bits();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule